// File: doc/BRIEF.md
# Reset Input Qualifier

This block sits between two asynchronous, active-low reset request pins and a processor core. It brings both requests into the core clock domain and turns them into clean single-cycle exception requests. A hard reset request is timed while it is held. The hard exception fires only when the request is released, and only if it was held for the minimum width. A request released too early sets a sticky error flag and produces no exception.

As soon as a hard request is seen, the core's output-drive enable is removed, so the pads can float. The enable comes back only after the hard exception pulse, or right at release when the request was too short. A soft reset is started only by a falling edge of its pin. The pin must then stay low for a set number of bus cycles, marked by a bus-cycle enable input, before a soft exception pulse is raised. A hard reset in progress cancels any soft reset being timed and suppresses its pulse.

Top module: `rst_qualifier`

## Requirements
- R1: After the synchronous reset `rst`, `drive_en` is 1 and `hard_exc`, `soft_exc` and `short_err` are 0.
- R2: When `hard_req_n` goes low, `drive_en` is 0 after the third rising clock edge that sees it low. This is always within five clocks of the raw pin.
- R3: A hard request held low for at least HARD_MIN (default 255) rising edges gives one `hard_exc` pulse of exactly one cycle. The pulse is high after the third rising edge that sees the pin high again.
- R4: A hard request held low for fewer than HARD_MIN edges produces no `hard_exc` and sets `short_err`. `short_err` stays 1 until `rst`, even across later valid hard requests.
- R5: The hard width count saturates. A request held far beyond HARD_MIN (for example 600 cycles) still gives exactly one `hard_exc` pulse.
- R6: After a valid hard request, `drive_en` returns to 1 in the cycle after the `hard_exc` pulse and is 0 during the pulse. After a short request, it returns to 1 in the cycle where the pulse would otherwise have appeared.
- R7: Only a falling edge of `soft_req_n` starts a soft request. Holding the pin low gives at most one `soft_exc` pulse per falling edge.
- R8: After the falling edge, `soft_exc` pulses only after SOFT_MIN (default 2) further cycles in which the pin is still low and `bus_tick` is 1. If the pin rises before that, the request is discarded with no pulse.
- R9: While a hard request is seen, any soft request being timed is cleared and `soft_exc` stays 0. A soft pin that went low during the hard request and is still low after it ends produces no pulse.
- R10: `soft_exc` is a single-cycle pulse and never coincides with `hard_exc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| hard_req_n | input | 1 | Asynchronous hard reset request, active low |
| soft_req_n | input | 1 | Asynchronous soft reset request, active low, falling-edge triggered |
| bus_tick | input | 1 | One-cycle mark of a bus cycle, used to time the soft request |
| drive_en | output | 1 | Output-drive enable for the core's pads; 0 means float |
| hard_exc | output | 1 | Single-cycle hard reset exception request |
| soft_exc | output | 1 | Single-cycle soft reset exception request |
| short_err | output | 1 | Sticky flag: a hard request was released too early |

## Verification
Completion of the soft width check and the arrival of a hard request can land on the same rising edge. The bench lowers the soft pin with `bus_tick` held high, then lowers the hard pin exactly two clocks later. The synchronized hard request then reaches the soft logic on the very edge where the soft pulse would have been issued. The outcome is judged at the ports: `soft_exc` must never pulse, either then or after the hard request ends with the soft pin still low, while `drive_en` must fall and one `hard_exc` pulse must follow the release.

// File: rtl/rstq_pkg.sv
`timescale 1ns/1ps
package rstq_pkg;
  localparam int DEF_HARD_MIN    = 255;
  localparam int DEF_SOFT_MIN    = 2;
  localparam int DEF_SYNC_STAGES = 2;

  typedef enum logic {
    SOFT_IDLE  = 1'b0,
    SOFT_ARMED = 1'b1
  } soft_st_t;
endpackage

// File: rtl/rstq_sync.sv
`timescale 1ns/1ps
module rstq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[g] <= '1;
      else     stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/rstq_hard.sv
`timescale 1ns/1ps
module rstq_hard #(
  parameter int HARD_MIN = 255
) (
  input  logic clk,
  input  logic rst,
  input  logic active,
  output logic exc,
  output logic oe,
  output logic err
);
  localparam int CNT_W = $clog2(HARD_MIN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HARD_MIN);

  logic [CNT_W-1:0] cnt;
  logic             was_active;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt        <= '0;
      was_active <= 1'b0;
      exc        <= 1'b0;
      oe         <= 1'b1;
      err        <= 1'b0;
    end else begin
      was_active <= active;
      exc        <= 1'b0;
      if (active) begin
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        oe <= 1'b0;
      end else if (was_active) begin
        cnt <= '0;
        if (cnt == CNT_MAX) begin
          exc <= 1'b1;
        end else begin
          err <= 1'b1;
          oe  <= 1'b1;
        end
      end else if (exc) begin
        oe <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/rstq_soft.sv
`timescale 1ns/1ps
module rstq_soft
  import rstq_pkg::*;
#(
  parameter int SOFT_MIN = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic tick,
  input  logic hard_active,
  output logic exc
);
  localparam int TW = $clog2(SOFT_MIN + 1);
  localparam logic [TW-1:0] T_LAST = TW'(SOFT_MIN - 1);

  soft_st_t      st;
  logic          prev;
  logic [TW-1:0] tcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SOFT_IDLE;
      prev <= 1'b1;
      tcnt <= '0;
      exc  <= 1'b0;
    end else begin
      prev <= pin_s;
      exc  <= 1'b0;
      if (hard_active) begin
        st   <= SOFT_IDLE;
        tcnt <= '0;
      end else if (prev && !pin_s) begin
        st   <= SOFT_ARMED;
        tcnt <= '0;
      end else if (st == SOFT_ARMED) begin
        if (pin_s) begin
          st <= SOFT_IDLE;
        end else if (tick) begin
          if (tcnt == T_LAST) begin
            exc <= 1'b1;
            st  <= SOFT_IDLE;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rst_qualifier.sv
`timescale 1ns/1ps
module rst_qualifier
  import rstq_pkg::*;
#(
  parameter int HARD_MIN    = DEF_HARD_MIN,
  parameter int SOFT_MIN    = DEF_SOFT_MIN,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst,
  input  logic hard_req_n,
  input  logic soft_req_n,
  input  logic bus_tick,
  output logic drive_en,
  output logic hard_exc,
  output logic soft_exc,
  output logic short_err
);
  logic [1:0] pins_s;
  logic       hard_active;

  rstq_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({hard_req_n, soft_req_n}),
    .dout(pins_s)
  );

  assign hard_active = ~pins_s[1];

  rstq_hard #(.HARD_MIN(HARD_MIN)) u_hard (
    .clk   (clk),
    .rst   (rst),
    .active(hard_active),
    .exc   (hard_exc),
    .oe    (drive_en),
    .err   (short_err)
  );

  rstq_soft #(.SOFT_MIN(SOFT_MIN)) u_soft (
    .clk        (clk),
    .rst        (rst),
    .pin_s      (pins_s[0]),
    .tick       (bus_tick),
    .hard_active(hard_active),
    .exc        (soft_exc)
  );
endmodule

// File: rtl/rst_qualifier_chk.sv
`timescale 1ns/1ps
module rst_qualifier_chk (
  input logic clk,
  input logic rst,
  input logic hard_req_n,
  input logic drive_en,
  input logic hard_exc,
  input logic soft_exc,
  input logic short_err
);
  logic [2:0] low_run;

  always_ff @(posedge clk) begin
    if (rst || hard_req_n) low_run <= '0;
    else if (low_run != 3'd7) low_run <= low_run + 1'b1;
  end

  // R2
  drive_off_chk: assert property (@(posedge clk) disable iff (rst)
    (low_run >= 3'd5) |-> !drive_en);

  // R3
  hard_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hard_exc |=> !hard_exc);

  // R4
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    short_err |=> short_err);

  // R6
  oe_after_exc_chk: assert property (@(posedge clk) disable iff (rst)
    hard_exc |-> !drive_en);

  // R10
  soft_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    soft_exc |=> !soft_exc);

  // R10
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    hard_exc |-> !soft_exc);
endmodule

bind rst_qualifier rst_qualifier_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .hard_req_n(hard_req_n),
  .drive_en  (drive_en),
  .hard_exc  (hard_exc),
  .soft_exc  (soft_exc),
  .short_err (short_err)
);

// File: tb/test_rst_qualifier.sv
`timescale 1ns/1ps
module test_rst_qualifier;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hard_req_n = 1'b1;
  logic soft_req_n = 1'b1;
  logic bus_tick = 1'b0;
  logic drive_en, hard_exc, soft_exc, short_err;

  int checks = 0;
  int errors = 0;
  int hard_seen = 0;
  int soft_seen = 0;

  always #5 clk = ~clk;

  rst_qualifier i_rst_qualifier (
    .clk       (clk),
    .rst       (rst),
    .hard_req_n(hard_req_n),
    .soft_req_n(soft_req_n),
    .bus_tick  (bus_tick),
    .drive_en  (drive_en),
    .hard_exc  (hard_exc),
    .soft_exc  (soft_exc),
    .short_err (short_err)
  );

  always @(negedge clk) begin
    if (hard_exc) hard_seen++;
    if (soft_exc) soft_seen++;
  end

  // {low length[15:8], bus_tick level[7:4], expected pulses[3:0]}, SOFT_MIN = 2
  localparam logic [15:0] SOFT_VEC [8] = '{
    16'h0110, 16'h0210, 16'h0311, 16'h0411,
    16'h1E11, 16'h1E00, 16'h0200, 16'h0C11
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hard_hold(input int n);
    hard_req_n = 1'b0;
    cyc(n);
    hard_req_n = 1'b1;
    cyc(6);
  endtask

  initial begin
    int h0, s0;
    cyc(3);
    rst = 1'b0;
    cyc(1);
    // R1 reset state
    chk(drive_en == 1'b1, "R1 drive_en", drive_en, 1);
    chk(hard_exc == 1'b0, "R1 hard_exc", hard_exc, 0);
    chk(soft_exc == 1'b0, "R1 soft_exc", soft_exc, 0);
    chk(short_err == 1'b0, "R1 short_err", short_err, 0);

    // Soft vector table (R7, R8)
    for (int v = 0; v < 8; v++) begin
      int len, expn;
      len  = int'(SOFT_VEC[v][15:8]);
      expn = int'(SOFT_VEC[v][3:0]);
      bus_tick = SOFT_VEC[v][4];
      s0 = soft_seen;
      soft_req_n = 1'b0;
      cyc(len);
      soft_req_n = 1'b1;
      cyc(6);
      chk(soft_seen - s0 == expn, "R8 soft width vector", soft_seen - s0, expn);
    end
    bus_tick = 1'b1;

    // R7 long hold: one pulse only
    s0 = soft_seen;
    soft_req_n = 1'b0;
    cyc(50);
    chk(soft_seen - s0 == 1, "R7 single pulse per edge", soft_seen - s0, 1);
    soft_req_n = 1'b1;
    cyc(6);

    // R2, R3, R6 exact timing at HARD_MIN = 255
    h0 = hard_seen;
    hard_req_n = 1'b0;
    cyc(2);
    chk(drive_en == 1'b1, "R2 drive_en before 3rd edge", drive_en, 1);
    cyc(1);
    chk(drive_en == 1'b0, "R2 drive_en after 3rd edge", drive_en, 0);
    cyc(252);
    hard_req_n = 1'b1;
    cyc(2);
    chk(hard_exc == 1'b0, "R3 no pulse before 3rd edge", hard_exc, 0);
    cyc(1);
    chk(hard_exc == 1'b1, "R3 pulse on 3rd edge", hard_exc, 1);
    chk(drive_en == 1'b0, "R6 drive_en low during pulse", drive_en, 0);
    cyc(1);
    chk(hard_exc == 1'b0, "R3 pulse one cycle", hard_exc, 0);
    chk(drive_en == 1'b1, "R6 drive_en back after pulse", drive_en, 1);
    cyc(4);
    chk(hard_seen - h0 == 1, "R3 pulse count", hard_seen - h0, 1);
    chk(short_err == 1'b0, "R4 no error on valid width", short_err, 0);

    // R5 saturation
    h0 = hard_seen;
    hard_hold(600);
    chk(hard_seen - h0 == 1, "R5 long hold one pulse", hard_seen - h0, 1);
    chk(short_err == 1'b0, "R5 no error on long hold", short_err, 0);

    // R4, R6 short hold
    h0 = hard_seen;
    hard_req_n = 1'b0;
    cyc(254);
    hard_req_n = 1'b1;
    cyc(2);
    chk(drive_en == 1'b0, "R6 drive_en low before release edge", drive_en, 0);
    cyc(1);
    chk(drive_en == 1'b1, "R6 drive_en back after short", drive_en, 1);
    chk(short_err == 1'b1, "R4 error set", short_err, 1);
    cyc(5);
    chk(hard_seen - h0 == 0, "R4 no pulse on short", hard_seen - h0, 0);

    // R4 sticky across a later valid request
    h0 = hard_seen;
    hard_hold(260);
    chk(hard_seen - h0 == 1, "R4 valid after short", hard_seen - h0, 1);
    chk(short_err == 1'b1, "R4 error sticky", short_err, 1);

    // R9 collision: hard seen on the edge where soft would complete
    h0 = hard_seen;
    s0 = soft_seen;
    soft_req_n = 1'b0;
    cyc(2);
    hard_req_n = 1'b0;
    cyc(3);
    chk(drive_en == 1'b0, "R9 drive_en low in collision", drive_en, 0);
    cyc(257);
    hard_req_n = 1'b1;
    cyc(30);
    chk(soft_seen - s0 == 0, "R9 soft suppressed", soft_seen - s0, 0);
    chk(hard_seen - h0 == 1, "R9 hard still issued", hard_seen - h0, 1);
    soft_req_n = 1'b1;
    cyc(6);
    chk(soft_seen - s0 == 0, "R9 no soft after release", soft_seen - s0, 0);

    // R10 fresh soft still works and never overlaps
    s0 = soft_seen;
    soft_req_n = 1'b0;
    cyc(8);
    soft_req_n = 1'b1;
    cyc(6);
    chk(soft_seen - s0 == 1, "R10 soft pulse after recovery", soft_seen - s0, 1);

    // R1 reset clears sticky error
    rst = 1'b1;
    cyc(2);
    rst = 1'b0;
    cyc(1);
    chk(short_err == 1'b0, "R1 short_err cleared", short_err, 0);
    chk(drive_en == 1'b1, "R1 drive_en after reset", drive_en, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule